// File: doc/BRIEF.md
# DRAM Refresh and Initialization Sequencer

This block keeps an asynchronous DRAM alive by issuing refresh cycles in which CAS is pulled low before RAS. The memory's own internal row counter then chooses the row, so the sequencer never supplies a row address. The array needs 4096 refresh cycles in every 64 ms window, which works out to one refresh about every 15.6 µs. An interval timer produces one refresh credit per period. A saturating pending counter holds these credits until the access controller releases the strobes.

After reset, the sequencer first waits out a power-up delay of at least 200 µs. It then runs a burst of warm-up refresh cycles, and only after that does it raise `ready`. Before `ready`, the sequencer owns the strobes outright. After `ready`, it raises `req` whenever refresh work is owed. It touches the strobes only while the access controller holds `gnt` high.

The access controller may hold off refresh, for example to finish a page. When the backlog grows past a threshold, the sequencer raises `urgent`. WE stays high throughout every refresh, because a low WE at the RAS falling edge would switch the memory into a test mode. All timings are given as clock-cycle parameters.

Top module: `dram_refresh_seq`

## Requirements
- R1: In reset and right after it, `ras_n`, `cas_n` and `we_n` are 1, `ready`, `req` and `urgent` are 0, and `own_bus` is 1.
- R2: `ready` rises only after at least POWERUP_CYC cycles plus INIT_CNT (default 8) complete refresh cycles. Exactly INIT_CNT RAS falling edges occur before `ready`. Once high, `ready` stays high until reset.
- R3: In every refresh, `cas_n` falls exactly CSR_CYC cycles before `ras_n` falls. `ras_n` then stays low for exactly RAS_CYC cycles, with `cas_n` held low throughout. Both strobes return high on the same clock edge.
- R4: `we_n` is 1 in every cycle in which `own_bus` is 1.
- R5: Every `cas_n` falling edge is preceded by at least RP_CYC consecutive cycles with both `ras_n` and `cas_n` high.
- R6: After `ready`, a refresh starts only on a clock edge where `gnt` is 1, so no strobe is active while `gnt` is 0 (`gnt` drops only while `own_bus` is 0). `own_bus` is 1 while a refresh is in progress or before `ready`.
- R7: After `ready`, one refresh is owed every INTERVAL_CYC cycles. `req` is 1 while any refresh is owed or in progress. With `gnt` given freely, the number of refreshes performed matches the number of elapsed intervals to within one.
- R8: The owed-refresh count saturates at 2^PEND_W-1 (default 15), and surplus credits are lost. `urgent` is 1 exactly when more than URGENT_THR (default 8) refreshes are owed.
- R9: `addr` is all zeros whenever `own_bus` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| gnt | input | 1 | Strobe ownership granted by the access controller |
| req | output | 1 | Refresh work owed or in progress |
| urgent | output | 1 | Backlog above the threshold |
| ready | output | 1 | Power-up and warm-up finished |
| own_bus | output | 1 | Sequencer is driving the strobes |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, held high |
| addr | output | ADDR_W | Address bus, zero while owned |

## Verification
The grant assertion assumes the access controller is well behaved: it withdraws `gnt` only while `own_bus` is low, and never in the middle of a refresh. The bench honours this by waiting for `own_bus` to read 0 before it lowers `gnt`. The stimulus mixes random grant-withholding windows of up to three intervals, which keeps the backlog short of saturation during the accounting phase, with a directed hold-off of twenty intervals that drives the counter into saturation and raises `urgent`. Strobe ordering, pulse widths and precharge gaps are measured edge by edge on every refresh, both during warm-up and in normal running.

// File: rtl/refresh_pkg.sv
package refresh_pkg;
  typedef enum logic [1:0] {PH_PWRUP, PH_INIT, PH_RUN} seq_phase_t;
  typedef enum logic [1:0] {SB_IDLE, SB_PRE, SB_CSR, SB_ACT} strobe_st_t;

  function automatic int max3(input int a, input int b, input int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction
endpackage

// File: rtl/rfs_interval.sv
module rfs_interval #(
  parameter int INTERVAL_CYC = 3900
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  output logic tick
);
  localparam int CW = (INTERVAL_CYC > 1) ? $clog2(INTERVAL_CYC) : 1;
  localparam logic [CW-1:0] LAST = CW'(INTERVAL_CYC - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) cnt <= '0;
    else if (en) cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
  end

  assign tick = en && (cnt == LAST);

  // ticks are never back to back
  assert_tick_spacing_R7: assert property (@(posedge clk) disable iff (rst)
    tick |=> !tick);
endmodule

// File: rtl/rfs_pending.sv
module rfs_pending #(
  parameter int PEND_W     = 4,
  parameter int URGENT_THR = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              inc,
  input  logic              dec,
  output logic [PEND_W-1:0] cnt,
  output logic              urgent
);
  localparam logic [PEND_W-1:0] FULL = '1;
  localparam logic [PEND_W-1:0] THR  = PEND_W'(URGENT_THR);

  always_ff @(posedge clk) begin
    if (rst) cnt <= '0;
    else if (inc && !dec) begin
      if (cnt != FULL) cnt <= cnt + 1'b1;
    end else if (dec && !inc) begin
      if (cnt != '0) cnt <= cnt - 1'b1;
    end
  end

  assign urgent = (cnt > THR);

  assert_pend_saturate_R8: assert property (@(posedge clk) disable iff (rst)
    (inc && !dec && cnt == FULL) |=> cnt == FULL);
  assert_no_underflow_R8: assert property (@(posedge clk) disable iff (rst)
    (dec && !inc && cnt == '0) |=> cnt == '0);
endmodule

// File: rtl/rfs_cbr_strobe.sv
module rfs_cbr_strobe
  import refresh_pkg::*;
#(
  parameter int RP_CYC  = 13,
  parameter int CSR_CYC = 2,
  parameter int RAS_CYC = 18
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic busy,
  output logic done,
  output logic ras_n,
  output logic cas_n
);
  localparam int MAXC = max3(RP_CYC, CSR_CYC, RAS_CYC);
  localparam int CW   = $clog2(MAXC + 1);

  strobe_st_t    st;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      st    <= SB_IDLE;
      cnt   <= '0;
      ras_n <= 1'b1;
      cas_n <= 1'b1;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (st)
        SB_IDLE: if (start) begin
          st  <= SB_PRE;
          cnt <= CW'(RP_CYC - 1);
        end
        SB_PRE: if (cnt == '0) begin
          st    <= SB_CSR;
          cas_n <= 1'b0;
          cnt   <= CW'(CSR_CYC - 1);
        end else cnt <= cnt - 1'b1;
        SB_CSR: if (cnt == '0) begin
          st    <= SB_ACT;
          ras_n <= 1'b0;
          cnt   <= CW'(RAS_CYC - 1);
        end else cnt <= cnt - 1'b1;
        SB_ACT: if (cnt == '0) begin
          st    <= SB_IDLE;
          ras_n <= 1'b1;
          cas_n <= 1'b1;
          done  <= 1'b1;
        end else cnt <= cnt - 1'b1;
        default: st <= SB_IDLE;
      endcase
    end
  end

  assign busy = (st != SB_IDLE);

  assert_cas_under_ras_R3: assert property (@(posedge clk) disable iff (rst)
    !ras_n |-> !cas_n);
  assert_cas_leads_ras_R3: assert property (@(posedge clk) disable iff (rst)
    $fell(ras_n) |-> $past(!cas_n));
  assert_strobes_rise_together_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(ras_n) |-> cas_n);
endmodule

// File: rtl/dram_refresh_seq.sv
module dram_refresh_seq
  import refresh_pkg::*;
#(
  parameter int INTERVAL_CYC = 3900,
  parameter int POWERUP_CYC  = 50000,
  parameter int INIT_CNT     = 8,
  parameter int RP_CYC       = 13,
  parameter int CSR_CYC      = 2,
  parameter int RAS_CYC      = 18,
  parameter int PEND_W       = 4,
  parameter int URGENT_THR   = 8,
  parameter int ADDR_W       = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              gnt,
  output logic              req,
  output logic              urgent,
  output logic              ready,
  output logic              own_bus,
  output logic              ras_n,
  output logic              cas_n,
  output logic              we_n,
  output logic [ADDR_W-1:0] addr
);
  localparam int PW = $clog2(POWERUP_CYC + 1);
  localparam int IW = $clog2(INIT_CNT + 1);
  localparam logic [PW-1:0] PU_LAST = PW'(POWERUP_CYC - 1);
  localparam logic [IW-1:0] IN_ALL  = IW'(INIT_CNT);

  seq_phase_t        ph;
  logic [PW-1:0]     pu_cnt;
  logic [IW-1:0]     issued;
  logic              start, busy, done, tick;
  logic [PEND_W-1:0] pend;

  always_comb begin
    start = 1'b0;
    if (!busy) begin
      if (ph == PH_INIT) start = (issued != IN_ALL);
      else if (ph == PH_RUN) start = gnt && (pend != '0);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ph     <= PH_PWRUP;
      pu_cnt <= '0;
      issued <= '0;
      ready  <= 1'b0;
    end else begin
      unique case (ph)
        PH_PWRUP: if (pu_cnt == PU_LAST) ph <= PH_INIT;
                  else pu_cnt <= pu_cnt + 1'b1;
        PH_INIT: begin
          if (start) issued <= issued + 1'b1;
          if (issued == IN_ALL && !busy) begin
            ph    <= PH_RUN;
            ready <= 1'b1;
          end
        end
        default: ph <= PH_RUN;
      endcase
    end
  end

  rfs_interval #(.INTERVAL_CYC(INTERVAL_CYC)) u_interval (
    .clk(clk), .rst(rst), .en(ready), .tick(tick));

  rfs_pending #(.PEND_W(PEND_W), .URGENT_THR(URGENT_THR)) u_pending (
    .clk(clk), .rst(rst), .inc(tick), .dec(start && ph == PH_RUN),
    .cnt(pend), .urgent(urgent));

  rfs_cbr_strobe #(.RP_CYC(RP_CYC), .CSR_CYC(CSR_CYC), .RAS_CYC(RAS_CYC)) u_strobe (
    .clk(clk), .rst(rst), .start(start), .busy(busy), .done(done),
    .ras_n(ras_n), .cas_n(cas_n));

  assign req     = (pend != '0) || busy;
  assign own_bus = !ready || busy;
  assign we_n    = 1'b1;
  assign addr    = '0;

  assert_ready_sticky_R2: assert property (@(posedge clk) disable iff (rst)
    ready |=> ready);
  assert_ready_after_done_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(ready) |-> $past(!busy));
  assert_strobe_needs_grant_R6: assert property (@(posedge clk) disable iff (rst)
    (ready && busy) |-> gnt);
  assert_urgent_implies_req_R8: assert property (@(posedge clk) disable iff (rst)
    urgent |-> req);
  assert_done_after_strobe_R3: assert property (@(posedge clk) disable iff (rst)
    done |-> $past(!ras_n));
endmodule

// File: tb/test_dram_refresh_seq.sv
module test_dram_refresh_seq;
  localparam int INT  = 300;
  localparam int PU   = 500;
  localparam int NI   = 8;
  localparam int RP   = 3;
  localparam int CSR  = 2;
  localparam int RAS  = 5;
  localparam int PW   = 4;
  localparam int THR  = 8;
  localparam int AW   = 12;

  logic clk = 1'b0, rst = 1'b1, gnt = 1'b0;
  logic req, urgent, ready, own_bus, ras_n, cas_n, we_n;
  logic [AW-1:0] addr;

  int checks = 0, errors = 0;
  int cyc = 0, ready_cyc = -1, init_falls = 0, run_falls = 0;
  int cas_lead = 0, ras_low = 0, hi_gap = 1000;
  logic prev_ras = 1'b1, prev_cas = 1'b1, prev_ready = 1'b0;

  always #2 clk = ~clk;

  dram_refresh_seq #(.INTERVAL_CYC(INT), .POWERUP_CYC(PU), .INIT_CNT(NI),
    .RP_CYC(RP), .CSR_CYC(CSR), .RAS_CYC(RAS), .PEND_W(PW),
    .URGENT_THR(THR), .ADDR_W(AW)) i_dram_refresh_seq (
    .clk(clk), .rst(rst), .gnt(gnt), .req(req), .urgent(urgent),
    .ready(ready), .own_bus(own_bus), .ras_n(ras_n), .cas_n(cas_n),
    .we_n(we_n), .addr(addr));

  function automatic int init_min();
    return PU + NI * (RP + CSR + RAS);
  endfunction
  function automatic int init_max();
    return init_min() + NI * 2 + 4;
  endfunction

  task automatic check(input string req_tag, input logic ok, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", req_tag, act, exp, cyc);
    end
  endtask

  // edge monitor, sampled away from the active edge
  always @(negedge clk) begin
    if (!rst) begin
      cyc++;
      if (own_bus) begin
        if (we_n !== 1'b1) check("R4", 1'b0, we_n, 1);
        if (addr !== '0) check("R9", 1'b0, addr, 0);
      end
      if (ready && !prev_ready) ready_cyc = cyc;
      if (prev_ready && !ready) check("R2", 1'b0, ready, 1);
      if (prev_cas && !cas_n) begin
        check("R5", hi_gap >= RP, hi_gap, RP);
        hi_gap = 0;
      end
      if (prev_ras && !ras_n) begin
        check("R3", cas_lead == CSR, cas_lead, CSR);
        if (!ready) init_falls++; else run_falls++;
      end
      if (!prev_ras && ras_n) begin
        check("R3", ras_low == RAS, ras_low, RAS);
        check("R3", cas_n === 1'b1, cas_n, 1);
      end
      if (ready && !ras_n && !gnt) check("R6", 1'b0, gnt, 1);
      if (!cas_n && ras_n) cas_lead++; else cas_lead = 0;
      if (!ras_n) ras_low++; else ras_low = 0;
      if (ras_n && cas_n) hi_gap++;
      prev_ras = ras_n; prev_cas = cas_n; prev_ready = ready;
    end
  end

  task automatic tick_cycles(input int n);
    for (int i = 0; i < n; i++) @(posedge clk);
    #1;
  endtask

  task automatic drop_grant();
    @(posedge clk); #1;
    while (own_bus) begin @(posedge clk); #1; end
    gnt = 1'b0;
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    tick_cycles(150000);
    check("WATCHDOG", 1'b0, 0, 1);
    finish_run();
  end

  initial begin
    int t0, dt, burst, start_falls;
    void'($urandom(32'd1357));
    tick_cycles(3);
    #1;
    // R1 reset state
    check("R1", ras_n === 1'b1 && cas_n === 1'b1 && we_n === 1'b1, {ras_n, cas_n, we_n}, 7);
    check("R1", ready === 1'b0 && req === 1'b0 && urgent === 1'b0, {ready, req, urgent}, 0);
    check("R1", own_bus === 1'b1, own_bus, 1);
    @(posedge clk); #1 rst = 1'b0;
    check("R1", ras_n === 1'b1 && ready === 1'b0, {ras_n, ready}, 2);

    // R2 power-up and warm-up
    while (!ready) begin @(posedge clk); #1; end
    tick_cycles(1);
    check("R2", ready_cyc >= init_min() && ready_cyc <= init_max(), ready_cyc, init_min());
    check("R2", init_falls == NI, init_falls, NI);
    check("R6", own_bus === 1'b0, own_bus, 0);

    // R7 first credit raises req
    t0 = cyc;
    while (!req) begin @(posedge clk); #1; end
    dt = cyc - t0 + (t0 - ready_cyc);
    check("R7", dt >= INT - 2 && dt <= INT + 3, dt, INT);
    check("R6", ras_n === 1'b1 && own_bus === 1'b0, {ras_n, own_bus}, 2);

    // random grant withholding, never long enough to saturate
    for (int r = 0; r < 30; r++) begin
      gnt = 1'b1;
      tick_cycles(50 + ($urandom % 550));
      drop_grant();
      tick_cycles($urandom % (3 * INT));
    end
    gnt = 1'b1;
    tick_cycles(2);
    while (req) begin @(posedge clk); #1; end
    tick_cycles(1);
    dt = (cyc - ready_cyc) / INT;
    check("R7", run_falls >= dt - 1 && run_falls <= dt + 1, run_falls, dt);
    check("R8", urgent === 1'b0, urgent, 0);

    // directed hold-off: urgent threshold then saturation
    drop_grant();
    t0 = cyc;
    while (!urgent) begin
      @(posedge clk); #1;
      if (cyc - t0 > 12 * INT) break;
    end
    dt = cyc - t0;
    check("R8", dt >= THR * INT && dt <= (THR + 1) * INT + 3, dt, (THR + 1) * INT);
    check("R7", req === 1'b1, req, 1);
    tick_cycles(20 * INT - dt);
    check("R8", urgent === 1'b1 && ras_n === 1'b1, {urgent, ras_n}, 3);
    start_falls = run_falls;
    gnt = 1'b1;
    tick_cycles(2);
    while (req) begin @(posedge clk); #1; end
    tick_cycles(1);
    burst = run_falls - start_falls;
    check("R8", burst >= 15 && burst <= 16, burst, 15);
    check("R8", urgent === 1'b0, urgent, 0);
    check("R2", ready === 1'b1, ready, 1);
    finish_run();
  end
endmodule